// File: doc/BRIEF.md
# Debug Trace Exception Controller

This block watches the retirement stream of a processor core and decides, one event at a time, whether the core must take a single-step trace exception, a branch trace exception or an instruction breakpoint exception, or must halt for an external debugger. It owns the two debug enable bits of the machine state. These are the single-step enable and the branch-trace enable. It also owns a saved copy of them, which it captures on exception entry and restores on a return-from-exception.

Some instruction classes never pass through the execution pipeline: the two synchronising barriers, the two return-from-exception forms and branches. Single-step does not see these classes, and only branch trace can catch them. When a stop is enabled while single-step is set, the block halts the core instead of raising a trace exception. A breakpoint hit wins over every other event. After the handler returns, the same instruction can then produce its trace exception. Requests are registered. An exception request waits for an acknowledge, and a halt request waits for a resume pulse. While either one is outstanding, no retire event is accepted.

Top module: `trc_ctl`

## Requirements
- R1: After reset, exc_req, halt_req, exc_vec, ms_step, ms_btr, ms_sav_step and ms_sav_btr are all zero.
- R2: An accepted retire with ms_step=1, brk_hit=0, stop_en=0 and a class of 0 (ALU), 1 (LDST) or 7 (MISC) raises exc_req on the next cycle with exc_vec = 0x00D00.
- R3: The classes 2 (BRANCH), 3 (ISYNC), 4 (SYNC), 5 (RFI) and 6 (RFCI) never raise a single-step trace exception or a halt, whatever ms_step and stop_en hold.
- R4: An accepted retire with ms_btr=1, br_done=1 and class 2, 5 or 6 raises exc_req with exc_vec = 0x00D00 on the next cycle. Without br_done, or for any other class, branch trace has no effect.
- R5: An accepted retire with ms_step=1, stop_en=1, brk_hit=0 and a class of 0, 1 or 7 sets halt_req on the next cycle. It raises no exception and leaves the machine state unchanged.
- R6: An accepted retire with brk_hit=1 raises exc_req with exc_vec = 0x01300, and this overrides trace and stop. The instruction counts as not retired, so a return class does not restore the state. A later retire of the same instruction without the hit then gives its trace exception.
- R7: On exception entry, ms_sav_step/ms_sav_btr take the state as it stands after the event, ms_step becomes 0 and ms_btr is kept.
- R8: An accepted retire of class 5 or 6 with brk_hit=0 copies the saved state into ms_step/ms_btr. This can re-enable single-step for the next instruction.
- R9: exc_req and exc_vec hold until exc_ack is high. halt_req holds until resume is high. An acknowledge with no request pending has no effect.
- R10: A retire is accepted only when exc_req and halt_req are both low. Otherwise it changes neither the state nor the requests.
- R11: When ms_wr_vld is high, ms_step/ms_btr load ms_wr_step/ms_wr_btr. This does not happen in a cycle that takes an exception or restores on a return.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rtr_vld | input | 1 | Retire event strobe |
| rtr_cls | input | 3 | Instruction class code of the retiring instruction |
| br_done | input | 1 | Branch or return completed successfully |
| brk_hit | input | 1 | Instruction address breakpoint matched this instruction |
| stop_en | input | 1 | Soft or hard stop enabled by the debugger |
| ms_wr_vld | input | 1 | Software write of the debug state bits |
| ms_wr_step | input | 1 | Single-step value to write |
| ms_wr_btr | input | 1 | Branch-trace value to write |
| exc_ack | input | 1 | Core has taken the pending exception |
| resume | input | 1 | Debugger resume pulse |
| exc_req | output | 1 | Exception request |
| exc_vec | output | VEC_W | Vector offset of the requested exception |
| halt_req | output | 1 | Level halt request |
| ms_step | output | 1 | Current single-step enable |
| ms_btr | output | 1 | Current branch-trace enable |
| ms_sav_step | output | 1 | Saved single-step enable |
| ms_sav_btr | output | 1 | Saved branch-trace enable |

## Verification
A wrong enable or saved bit shows up one cycle after the next accepted retire, either as an exception that is missing or extra, or as a halt in place of a trace. A wrong restore shows one retire later, when the state comes back from the saved copy. A request or halt flag stuck in the wrong state blocks every later retire, so the next trace or breakpoint check fails at once. The bench steps the state through exception entry, return and breakpoint re-execution so that every saved-copy path reaches the ports.

// File: rtl/trc_pkg.sv
package trc_pkg;
   localparam int CLS_W = 3;
   localparam int NCLS  = 1 << CLS_W;

   typedef enum logic [CLS_W-1:0] {
      CL_ALU    = 3'd0,
      CL_LDST   = 3'd1,
      CL_BRANCH = 3'd2,
      CL_ISYNC  = 3'd3,
      CL_SYNC   = 3'd4,
      CL_RFI    = 3'd5,
      CL_RFCI   = 3'd6,
      CL_MISC   = 3'd7
   } icls_e;

   // classes that bypass the execution pipeline (single-step blind)
   localparam logic [NCLS-1:0] SKIP_MASK = 8'b0111_1100;
   // classes that branch trace watches
   localparam logic [NCLS-1:0] BTR_MASK  = 8'b0110_0100;
   // return-from-exception classes
   localparam logic [NCLS-1:0] RET_MASK  = 8'b0110_0000;

   typedef struct packed {
      logic step;
      logic btr;
   } mstate_t;
endpackage

// File: rtl/trc_classify.sv
module trc_classify
   import trc_pkg::*;
(
   input  logic [CLS_W-1:0] cls,
   output logic             skip,
   output logic             btr_ok,
   output logic             is_ret
);
   logic [NCLS-1:0] sel;

   for (genvar i = 0; i < NCLS; i++) begin : g_sel
      assign sel[i] = (cls == CLS_W'(i));
   end

   assign skip   = |(sel & SKIP_MASK);
   assign btr_ok = |(sel & BTR_MASK);
   assign is_ret = |(sel & RET_MASK);
endmodule

// File: rtl/trc_decide.sv
module trc_decide (
   input  logic accept,
   input  logic brk_hit,
   input  logic stop_en,
   input  logic br_done,
   input  logic cur_step,
   input  logic cur_btr,
   input  logic skip,
   input  logic btr_ok,
   input  logic is_ret,
   output logic take_exc,
   output logic take_brk,
   output logic take_halt,
   output logic restore
);
   logic retired;
   logic step_trc;
   logic btr_trc;

   always_comb begin
      take_brk  = accept & brk_hit;
      retired   = accept & ~brk_hit;
      take_halt = retired & cur_step & ~skip & stop_en;
      step_trc  = retired & cur_step & ~skip & ~stop_en;
      btr_trc   = retired & cur_btr & btr_ok & br_done & ~take_halt;
      take_exc  = take_brk | step_trc | btr_trc;
      restore   = retired & ~take_halt & is_ret;
   end
endmodule

// File: rtl/trc_mstate.sv
module trc_mstate
   import trc_pkg::*;
(
   input  logic    clk,
   input  logic    rst_n,
   input  logic    take_exc,
   input  logic    restore,
   input  logic    wr_vld,
   input  mstate_t wr_val,
   output mstate_t cur,
   output mstate_t sav
);
   mstate_t nxt;

   assign nxt = restore ? sav : cur;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cur <= '0;
         sav <= '0;
      end else if (take_exc) begin
         sav      <= nxt;
         cur.step <= 1'b0;
         cur.btr  <= nxt.btr;
      end else if (restore) begin
         cur <= sav;
      end else if (wr_vld) begin
         cur <= wr_val;
      end
   end
endmodule

// File: rtl/trc_reqgen.sv
module trc_reqgen #(
   parameter int               VEC_W     = 20,
   parameter logic [VEC_W-1:0] TRACE_VEC = 20'h00D00,
   parameter logic [VEC_W-1:0] BRK_VEC   = 20'h01300
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             take_exc,
   input  logic             take_brk,
   input  logic             take_halt,
   input  logic             exc_ack,
   input  logic             resume,
   output logic             exc_req,
   output logic [VEC_W-1:0] exc_vec,
   output logic             halt_req
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         exc_req <= 1'b0;
         exc_vec <= '0;
      end else if (take_exc) begin
         exc_req <= 1'b1;
         exc_vec <= take_brk ? BRK_VEC : TRACE_VEC;
      end else if (exc_ack) begin
         exc_req <= 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         halt_req <= 1'b0;
      else if (take_halt) halt_req <= 1'b1;
      else if (resume)    halt_req <= 1'b0;
   end
endmodule

// File: rtl/trc_ctl.sv
module trc_ctl
   import trc_pkg::*;
#(
   parameter int               VEC_W     = 20,
   parameter logic [VEC_W-1:0] TRACE_VEC = 20'h00D00,
   parameter logic [VEC_W-1:0] BRK_VEC   = 20'h01300
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             rtr_vld,
   input  logic [2:0]       rtr_cls,
   input  logic             br_done,
   input  logic             brk_hit,
   input  logic             stop_en,
   input  logic             ms_wr_vld,
   input  logic             ms_wr_step,
   input  logic             ms_wr_btr,
   input  logic             exc_ack,
   input  logic             resume,
   output logic             exc_req,
   output logic [VEC_W-1:0] exc_vec,
   output logic             halt_req,
   output logic             ms_step,
   output logic             ms_btr,
   output logic             ms_sav_step,
   output logic             ms_sav_btr
);
   localparam int MIN_VEC_W = 13;

   if (VEC_W < MIN_VEC_W) begin : g_bad_w
      $error("trc_ctl: VEC_W too narrow for the vector offsets");
   end
   if (TRACE_VEC == BRK_VEC) begin : g_bad_vec
      $error("trc_ctl: trace and breakpoint vectors must differ");
   end
   if (CLS_W != 3) begin : g_bad_cls
      $error("trc_ctl: class port width does not match CLS_W");
   end

   logic    accept;
   logic    skip, btr_ok, is_ret;
   logic    take_exc, take_brk, take_halt, restore;
   mstate_t cur, sav, wr_val;

   assign accept = rtr_vld & ~exc_req & ~halt_req;
   assign wr_val = '{step: ms_wr_step, btr: ms_wr_btr};

   trc_classify u_cls (
      .cls    (rtr_cls),
      .skip   (skip),
      .btr_ok (btr_ok),
      .is_ret (is_ret)
   );

   trc_decide u_dec (
      .accept    (accept),
      .brk_hit   (brk_hit),
      .stop_en   (stop_en),
      .br_done   (br_done),
      .cur_step  (cur.step),
      .cur_btr   (cur.btr),
      .skip      (skip),
      .btr_ok    (btr_ok),
      .is_ret    (is_ret),
      .take_exc  (take_exc),
      .take_brk  (take_brk),
      .take_halt (take_halt),
      .restore   (restore)
   );

   trc_mstate u_ms (
      .clk      (clk),
      .rst_n    (rst_n),
      .take_exc (take_exc),
      .restore  (restore),
      .wr_vld   (ms_wr_vld),
      .wr_val   (wr_val),
      .cur      (cur),
      .sav      (sav)
   );

   trc_reqgen #(
      .VEC_W     (VEC_W),
      .TRACE_VEC (TRACE_VEC),
      .BRK_VEC   (BRK_VEC)
   ) u_req (
      .clk       (clk),
      .rst_n     (rst_n),
      .take_exc  (take_exc),
      .take_brk  (take_brk),
      .take_halt (take_halt),
      .exc_ack   (exc_ack),
      .resume    (resume),
      .exc_req   (exc_req),
      .exc_vec   (exc_vec),
      .halt_req  (halt_req)
   );

   assign ms_step     = cur.step;
   assign ms_btr      = cur.btr;
   assign ms_sav_step = sav.step;
   assign ms_sav_btr  = sav.btr;
endmodule

// File: rtl/trc_ctl_chk.sv
module trc_ctl_chk #(
   parameter int               VEC_W     = 20,
   parameter logic [VEC_W-1:0] TRACE_VEC = 20'h00D00,
   parameter logic [VEC_W-1:0] BRK_VEC   = 20'h01300
) (
   input logic             clk,
   input logic             rst_n,
   input logic             rtr_vld,
   input logic [2:0]       rtr_cls,
   input logic             brk_hit,
   input logic             stop_en,
   input logic             ms_wr_vld,
   input logic             exc_ack,
   input logic             resume,
   input logic             exc_req,
   input logic [VEC_W-1:0] exc_vec,
   input logic             halt_req,
   input logic             ms_step,
   input logic             ms_btr
);
   logic idle_in;
   assign idle_in = rtr_vld & ~exc_req & ~halt_req;

   p_step_trace_r2: assert property (@(posedge clk) disable iff (!rst_n)
      idle_in && !brk_hit && ms_step && !stop_en && rtr_cls == 3'd0
      |=> exc_req && exc_vec == TRACE_VEC);

   p_skip_sync_r3: assert property (@(posedge clk) disable iff (!rst_n)
      idle_in && !brk_hit && (rtr_cls == 3'd3 || rtr_cls == 3'd4)
      |=> !exc_req && !halt_req);

   p_stop_halts_r5: assert property (@(posedge clk) disable iff (!rst_n)
      idle_in && !brk_hit && ms_step && stop_en && rtr_cls == 3'd0
      |=> halt_req && !exc_req);

   p_brk_first_r6: assert property (@(posedge clk) disable iff (!rst_n)
      idle_in && brk_hit |=> exc_req && exc_vec == BRK_VEC);

   p_entry_clr_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(exc_req) |-> !ms_step);

   p_exc_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      exc_req && !exc_ack |=> exc_req && $stable(exc_vec));

   p_halt_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      halt_req && !resume |=> halt_req);

   p_blocked_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (exc_req || halt_req) && !ms_wr_vld |=> $stable(ms_step) && $stable(ms_btr));
endmodule

bind trc_ctl trc_ctl_chk #(
   .VEC_W     (VEC_W),
   .TRACE_VEC (TRACE_VEC),
   .BRK_VEC   (BRK_VEC)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .rtr_vld   (rtr_vld),
   .rtr_cls   (rtr_cls),
   .brk_hit   (brk_hit),
   .stop_en   (stop_en),
   .ms_wr_vld (ms_wr_vld),
   .exc_ack   (exc_ack),
   .resume    (resume),
   .exc_req   (exc_req),
   .exc_vec   (exc_vec),
   .halt_req  (halt_req),
   .ms_step   (ms_step),
   .ms_btr    (ms_btr)
);

// File: tb/trc_ctl_bench.sv
`timescale 1ns/1ps
module trc_ctl_bench;
   localparam int VEC_W = 20;
   localparam logic [VEC_W-1:0] TRC = 20'h00D00;
   localparam logic [VEC_W-1:0] BRK = 20'h01300;
   localparam logic [2:0] C_ALU = 3'd0, C_LDST = 3'd1, C_BR = 3'd2, C_ISY = 3'd3,
                          C_SYN = 3'd4, C_RFI = 3'd5, C_RFCI = 3'd6, C_MISC = 3'd7;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic rtr_vld = 0, br_done = 0, brk_hit = 0, stop_en = 0;
   logic [2:0] rtr_cls = '0;
   logic ms_wr_vld = 0, ms_wr_step = 0, ms_wr_btr = 0, exc_ack = 0, resume = 0;
   logic exc_req, halt_req, ms_step, ms_btr, ms_sav_step, ms_sav_btr;
   logic [VEC_W-1:0] exc_vec;

   int n_run = 0, n_fail = 0;
   bit done = 0;

   always #2 clk = ~clk;

   trc_ctl u_trc_ctl (
      .clk(clk), .rst_n(rst_n), .rtr_vld(rtr_vld), .rtr_cls(rtr_cls),
      .br_done(br_done), .brk_hit(brk_hit), .stop_en(stop_en),
      .ms_wr_vld(ms_wr_vld), .ms_wr_step(ms_wr_step), .ms_wr_btr(ms_wr_btr),
      .exc_ack(exc_ack), .resume(resume), .exc_req(exc_req), .exc_vec(exc_vec),
      .halt_req(halt_req), .ms_step(ms_step), .ms_btr(ms_btr),
      .ms_sav_step(ms_sav_step), .ms_sav_btr(ms_sav_btr)
   );

   task automatic check(string what, logic [31:0] act, logic [31:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", what, act, exp);
      end
   endtask

   // one clock: drive at negedge, sample 1 ns after the rising edge
   task automatic cyc(logic rv, logic [2:0] cl, logic br, logic bk, logic st,
                      logic wv, logic ws, logic wb, logic ak, logic rs);
      @(negedge clk);
      rtr_vld = rv; rtr_cls = cl; br_done = br; brk_hit = bk; stop_en = st;
      ms_wr_vld = wv; ms_wr_step = ws; ms_wr_btr = wb; exc_ack = ak; resume = rs;
      @(posedge clk);
      #1;
   endtask

   task automatic idle();           cyc(0, C_ALU, 0, 0, 0, 0, 0, 0, 0, 0); endtask
   task automatic wr(logic s, logic b); cyc(0, C_ALU, 0, 0, 0, 1, s, b, 0, 0); endtask
   task automatic ret(logic [2:0] cl, logic br, logic bk, logic st);
      cyc(1, cl, br, bk, st, 0, 0, 0, 0, 0);
   endtask
   task automatic ack();            cyc(0, C_ALU, 0, 0, 0, 0, 0, 0, 1, 1); endtask

   // {step, btr, cls[2:0], br, brk, stop, exp_req, exp_is_brk, exp_halt, exp_step_after}
   localparam int NROW = 14;
   localparam logic [11:0] TBL [NROW] = '{
      {1'b1, 1'b0, C_ALU,  1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0}, // R2
      {1'b1, 1'b0, C_LDST, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0}, // R2
      {1'b1, 1'b0, C_ISY,  1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1}, // R3
      {1'b1, 1'b0, C_SYN,  1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1}, // R3
      {1'b1, 1'b0, C_BR,   1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1}, // R3
      {1'b0, 1'b1, C_BR,   1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0}, // R4
      {1'b0, 1'b1, C_BR,   1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0}, // R4
      {1'b0, 1'b1, C_ALU,  1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0}, // R4
      {1'b1, 1'b0, C_ALU,  1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1}, // R5
      {1'b1, 1'b0, C_ISY,  1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1}, // R3
      {1'b1, 1'b0, C_ALU,  1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0}, // R6
      {1'b0, 1'b0, C_MISC, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0}, // R6
      {1'b1, 1'b1, C_BR,   1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0}, // R4
      {1'b0, 1'b0, C_MISC, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0}  // R2
   };

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_run++; n_fail++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      #1;
      // R1 reset state
      check("R1 exc_req", exc_req, 0);
      check("R1 halt_req", halt_req, 0);
      check("R1 exc_vec", exc_vec, 0);
      check("R1 state", {ms_step, ms_btr, ms_sav_step, ms_sav_btr}, 0);
      @(negedge clk); rst_n = 1'b1;

      // table walk: R2 R3 R4 R5 R6
      for (int i = 0; i < NROW; i++) begin
         logic [11:0] r;
         string tag;
         r = TBL[i];
         tag = $sformatf("R2/R3/R4/R5/R6 row %0d", i);
         wr(r[11], r[10]);
         ret(r[9:7], r[6], r[5], r[4]);
         check({tag, " exc_req"}, exc_req, r[3]);
         if (r[3]) check({tag, " exc_vec"}, exc_vec, r[2] ? BRK : TRC);
         check({tag, " halt_req"}, halt_req, r[1]);
         check({tag, " ms_step"}, ms_step, r[0]);
         check({tag, " ms_btr kept"}, ms_btr, r[10]);
         ack();
         check({tag, " cleared"}, {exc_req, halt_req}, 0);
      end

      // R9 R10: exception held until acknowledge, retires blocked
      wr(1, 0);
      ret(C_ALU, 0, 0, 0);
      check("R2 trace", exc_req, 1);
      idle(); idle(); idle();
      check("R9 exc held", exc_req, 1);
      ret(C_ALU, 0, 1, 0);
      check("R10 vec unchanged while pending", exc_vec, TRC);
      check("R10 still pending", exc_req, 1);
      ack();
      check("R9 exc released", exc_req, 0);
      ack();
      check("R9 ack with none pending", {exc_req, halt_req, ms_step}, 0);

      // R9 R10: halt held until resume; saved now {1,0}
      wr(1, 1);
      ret(C_ALU, 0, 0, 1);
      check("R5 halt", halt_req, 1);
      check("R5 no exc", exc_req, 0);
      idle(); idle();
      check("R9 halt held", halt_req, 1);
      ret(C_RFI, 0, 0, 0);
      check("R10 no restore while halted", ms_btr, 1);
      check("R10 no exc while halted", exc_req, 0);
      cyc(0, C_ALU, 0, 0, 0, 0, 0, 0, 0, 1);
      check("R9 halt released", halt_req, 0);

      // R7 R8: entry saves and clears, return restores
      wr(1, 0);
      ret(C_ALU, 0, 0, 0);
      check("R7 step cleared", ms_step, 0);
      check("R7 saved step", ms_sav_step, 1);
      ack();
      ret(C_ALU, 0, 0, 0);
      check("R7 no trace in handler", exc_req, 0);
      ret(C_RFI, 0, 0, 0);
      check("R8 step restored", ms_step, 1);
      check("R8 no exc on return", exc_req, 0);
      ret(C_LDST, 0, 0, 0);
      check("R8 trace after return", exc_req, 1);
      ack();

      // R6: breakpoint first, trace after the handler returns
      wr(1, 0);
      ret(C_RFI, 0, 1, 0);
      check("R6 brk vec", exc_vec, BRK);
      check("R6 brk req", exc_req, 1);
      check("R6 step cleared", ms_step, 0);
      ack();
      ret(C_RFCI, 0, 0, 0);
      check("R8 rfci restores", ms_step, 1);
      ret(C_ALU, 0, 0, 0);
      check("R6 trace follows", {exc_req, exc_vec}, {1'b1, TRC});
      ack();

      // R4 R7 R8: branch-traced return re-enters with restored state
      wr(1, 1);
      ret(C_ALU, 0, 0, 0);
      check("R7 saved both", {ms_sav_step, ms_sav_btr}, 2'b11);
      ack();
      ret(C_RFI, 1, 0, 0);
      check("R4 return traced", {exc_req, exc_vec}, {1'b1, TRC});
      check("R7 state after traced return", {ms_step, ms_btr, ms_sav_step, ms_sav_btr}, 4'b0111);
      ack();

      // R11: write versus same-cycle events
      cyc(1, C_ALU, 0, 0, 0, 1, 1, 0, 0, 0);
      check("R11 write with plain retire", {exc_req, ms_step, ms_btr}, 3'b010);
      cyc(1, C_ALU, 0, 0, 0, 1, 1, 1, 0, 0);
      check("R11 write lost to exception", {exc_req, ms_step, ms_btr}, 3'b100);
      ack();

      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule